// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block is a master for an external memory bus. It runs one single read or write cycle at a time. An internal requester presents an address, a size code, a direction and write data. The block turns that request into a bus cycle made of half-clock states. It drives the address, direction, size, cycle-start strobe, cycle-active flag, chip select, byte-lane strobes, read enable and write-data drive enable. It then waits for the target's acknowledge. When the cycle ends it hands back read data together with a one-clock completion pulse.

The block runs on a core clock at twice the bus clock rate. It generates the bus clock itself, so every bus output changes on a core edge that lines up with a bus clock edge. A cycle uses the half states S0 to S5. S0, S2 and S4 fall in the bus-clock-high half, and S1, S3 and S5 fall in the low half. If acknowledge is sampled at the end of S1, the cycle skips S2 and S3 (fast termination). Otherwise S2/S3 pairs repeat as wait states until acknowledge is sampled. All bus strobes are active high.

Top module: `ebus_master`

## Requirements
- R1: While reset is held and right after it, tip_o, ts_o, cs_o, be_o, oe_o, dat_oe_o, done_o and busy_o are all 0, and rw_o is 1.
- R2: A request is accepted only while the block is idle. The cycle's first half (S0) starts on a rising bus clock edge. From S0, addr_o, size_o and rw_o (1 = read, 0 = write) show the request, and they stay unchanged until the cycle ends.
- R3: cs_o and, for reads only, oe_o assert on the falling bus edge that follows S0. They stay asserted through S5 and drop together with tip_o at the rising edge that ends S5.
- R4: ts_o is high for exactly S0 and S1 and drops at the next rising bus edge.
- R5: For a write, dat_oe_o rises at the rising edge that ends S1 and stays high through S5, with wdata_o equal to the request's data. For a read, dat_oe_o never asserts.
- R6: Acknowledge is sampled only at rising bus edges that end S1 or S3. If a cycle's acknowledge first comes at the end of S3 after n extra S2/S3 pairs, the cycle has n whole-clock wait states, and tip_o is high for 6+2n core clocks.
- R7: Acknowledge sampled at the end of S1 gives fast termination: S2 and S3 are skipped and tip_o is high for 4 core clocks.
- R8: Read data is taken from rdata_i at the rising edge where acknowledge is sampled. It appears on rdata_o with a one-core-clock done_o pulse in the clock right after S5, and it holds afterwards.
- R9: be_o follows size code and address bits [1:0]. Code 0 (byte) gives lane 1<<addr[1:0]. Code 1 (halfword) gives 4'b0011 when addr[1]=0 and 4'b1100 otherwise. Codes 2 and 3 give 4'b1111. be_o is 0 whenever cs_o is 0.
- R10: A request raised while a cycle is running is ignored. The bus address does not change, and no second cycle starts if the request is withdrawn before the first cycle ends.
- R11: Between transfers rw_o keeps the direction of the last cycle.
- R12: bclk_o toggles on every core clock edge, giving a 50% duty bus clock at half the core rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transfer request, held until busy_o rises |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Transfer address |
| req_size_i | input | 2 | Size code (0 byte, 1 halfword, 2/3 word) |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | A bus cycle is in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Captured read data |
| bclk_o | output | 1 | Generated bus clock |
| addr_o | output | AW | Bus address |
| rw_o | output | 1 | Direction, 1 = read |
| size_o | output | 2 | Bus size code |
| ts_o | output | 1 | Cycle-start strobe |
| tip_o | output | 1 | Cycle-active flag |
| cs_o | output | 1 | Chip select |
| be_o | output | 4 | Byte-lane strobes |
| oe_o | output | 1 | Read enable toward the target |
| dat_oe_o | output | 1 | Write-data drive enable |
| wdata_o | output | 32 | Write data onto the bus |
| ack_i | input | 1 | Transfer acknowledge from the target |
| rdata_i | input | 32 | Read data from the target |

## Verification
The bench models a target whose acknowledge delay can be set. A delay of zero gives fast termination. It checks every strobe half by half against the expected half-state, so a chip select that rose with S0, a start strobe held into S2, or a write drive that began in S1 or continued past S5 would show up at once. A read-data value that is valid only in the acknowledge clock catches capture at the wrong edge. Cycle length is measured for zero, one and three wait states, so a miscounted wait loop is caught. A request raised mid-cycle with a different address, and an idle gap after each transfer, show whether the block restarts or loses its held direction.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int BUS_BYTES = 4;
    localparam int BUS_DW    = 8 * BUS_BYTES;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_S0,
        SQ_S1,
        SQ_S2,
        SQ_S3,
        SQ_S4,
        SQ_S5
    } seq_st_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } xfer_size_t;

    // Byte lanes touched by a transfer of the given size at the given offset.
    function automatic logic [BUS_BYTES-1:0] lane_mask(input logic [1:0] ofs,
                                                       input logic [1:0] sz);
        logic [BUS_BYTES-1:0] m;
        case (xfer_size_t'(sz))
            SZ_BYTE: m = BUS_BYTES'(1) << ofs;
            SZ_HALF: m = ofs[1] ? 4'b1100 : 4'b0011;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ebus_phase.sv
module ebus_phase (
    input  logic clk,
    input  logic rst,
    output logic hi_o
);
    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ~ph_q;
    end

    assign hi_o = ph_q;

    AST_BCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (hi_o != $past(hi_o)));  // R12
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hi_i,
    input  logic    req_i,
    input  logic    ack_i,
    output seq_st_t st_o,
    output logic    start_o,
    output logic    cap_o,
    output logic    fin_o
);
    seq_st_t st_q, st_d;

    // Accept only in the low half, so S0 begins on a rising bus edge.
    assign start_o = (st_q == SQ_IDLE) && !hi_i && req_i;
    assign cap_o   = ((st_q == SQ_S1) || (st_q == SQ_S3)) && ack_i;
    assign fin_o   = (st_q == SQ_S5);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: if (start_o) st_d = SQ_S0;
            SQ_S0:   st_d = SQ_S1;
            SQ_S1:   st_d = ack_i ? SQ_S4 : SQ_S2;
            SQ_S2:   st_d = SQ_S3;
            SQ_S3:   st_d = ack_i ? SQ_S4 : SQ_S2;
            SQ_S4:   st_d = SQ_S5;
            SQ_S5:   st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

    assign st_o = st_q;

    AST_S0_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_S0) |-> hi_i);  // R2
    AST_S4_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_S4) |-> hi_i);  // R6
    AST_S4_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_S4) |-> $past(ack_i));  // R7
endmodule

// File: rtl/ebus_xfer.sv
module ebus_xfer
    import ebus_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cap_i,
    input  logic              fin_i,
    input  logic              wr_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [1:0]        size_i,
    input  logic [BUS_DW-1:0] wdata_i,
    input  logic [BUS_DW-1:0] bus_rdata_i,
    output logic [AW-1:0]     addr_o,
    output logic              rd_o,
    output logic [1:0]        size_o,
    output logic [BUS_DW-1:0] wdata_o,
    output logic [BUS_DW-1:0] rdata_o,
    output logic              done_o
);
    logic [AW-1:0]     addr_q;
    logic              rd_q;
    logic [1:0]        size_q;
    logic [BUS_DW-1:0] wdata_q, rdata_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            rd_q    <= 1'b1;
            size_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (start_i) begin
                addr_q  <= addr_i;
                rd_q    <= ~wr_i;
                size_q  <= size_i;
                wdata_q <= wdata_i;
            end
            if (cap_i && rd_q) rdata_q <= bus_rdata_i;
            done_q <= fin_i;
        end
    end

    assign addr_o  = addr_q;
    assign rd_o    = rd_q;
    assign size_o  = size_q;
    assign wdata_o = wdata_q;
    assign rdata_o = rdata_q;
    assign done_o  = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R8
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(addr_o) && $stable(rd_o)));  // R10
endmodule

// File: rtl/ebus_master.sv
module ebus_master
    import ebus_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [AW-1:0]     req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [BUS_DW-1:0] req_wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BUS_DW-1:0] rdata_o,
    output logic              bclk_o,
    output logic [AW-1:0]     addr_o,
    output logic              rw_o,
    output logic [1:0]        size_o,
    output logic              ts_o,
    output logic              tip_o,
    output logic              cs_o,
    output logic [BUS_BYTES-1:0] be_o,
    output logic              oe_o,
    output logic              dat_oe_o,
    output logic [BUS_DW-1:0] wdata_o,
    input  logic              ack_i,
    input  logic [BUS_DW-1:0] rdata_i
);
    logic    hi;
    seq_st_t st;
    logic    start, cap, fin, rd;

    ebus_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .hi_o (hi)
    );

    ebus_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .hi_i    (hi),
        .req_i   (req_i),
        .ack_i   (ack_i),
        .st_o    (st),
        .start_o (start),
        .cap_o   (cap),
        .fin_o   (fin)
    );

    ebus_xfer #(.AW(AW)) u_xfer (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .cap_i       (cap),
        .fin_i       (fin),
        .wr_i        (req_wr_i),
        .addr_i      (req_addr_i),
        .size_i      (req_size_i),
        .wdata_i     (req_wdata_i),
        .bus_rdata_i (rdata_i),
        .addr_o      (addr_o),
        .rd_o        (rd),
        .size_o      (size_o),
        .wdata_o     (wdata_o),
        .rdata_o     (rdata_o),
        .done_o      (done_o)
    );

    // Strobes decode from the registered half-state, so each one moves
    // on the core edge that coincides with its bus clock edge.
    always_comb begin
        tip_o    = (st != SQ_IDLE);
        ts_o     = (st == SQ_S0) || (st == SQ_S1);
        cs_o     = tip_o && !ts_o || (st == SQ_S1);
        oe_o     = cs_o && rd;
        dat_oe_o = !rd && ((st == SQ_S2) || (st == SQ_S3) ||
                           (st == SQ_S4) || (st == SQ_S5));
        be_o     = cs_o ? lane_mask(addr_o[1:0], size_o) : '0;
    end

    assign busy_o = tip_o;
    assign bclk_o = hi;
    assign rw_o   = rd;

    AST_CS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_o) |-> !bclk_o);  // R3
    AST_CS_IN_TIP: assert property (@(posedge clk) disable iff (rst)
        cs_o |-> tip_o);  // R3
    AST_TS_OVERLAPS_CS: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_o) |-> ts_o);  // R4
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        oe_o |-> !dat_oe_o);  // R5
    AST_DRIVE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_oe_o) |-> (bclk_o && !ts_o));  // R5
endmodule

// File: tb/sim_ebus_master.sv
module sim_ebus_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, wr = 1'b0;
    logic [23:0] addr = '0;
    logic [1:0]  sz = '0;
    logic [31:0] wd = '0;
    logic        ack = 1'b0;
    logic [31:0] bus_rd = 32'hDEAD_BEEF;

    logic        busy, done, bclk, rw, ts, tip, cs, oe, doe;
    logic [31:0] rdata, wdata_b;
    logic [23:0] addr_b;
    logic [1:0]  size_b;
    logic [3:0]  be;

    int checks = 0, fails = 0, cyc = 0;

    always #5 clk = ~clk;

    ebus_master #(.AW(24)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .req_wr_i(wr), .req_addr_i(addr),
        .req_size_i(sz), .req_wdata_i(wd), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .bclk_o(bclk), .addr_o(addr_b), .rw_o(rw),
        .size_o(size_b), .ts_o(ts), .tip_o(tip), .cs_o(cs), .be_o(be),
        .oe_o(oe), .dat_oe_o(doe), .wdata_o(wdata_b), .ack_i(ack),
        .rdata_i(bus_rd)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] a, input logic [1:0] s);
        if (s == 2'd0) return 4'b0001 << a;
        if (s == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    // One transfer with a target that acknowledges after d bus clocks
    // (d=0 fast termination, d>=1 means d-1 wait states).
    task automatic do_xfer(input logic w, input logic [23:0] a, input logic [1:0] s,
                           input logic [31:0] wdv, input int d,
                           input logic [31:0] sd, input bit poke);
        int  i = -1;
        int  len = 4 + 2 * d;
        bit  ended = 0;
        logic [3:0] eb = exp_be(a[1:0], s);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; sz = s; wd = wdv;
        for (int t = 0; t < 100 && !ended; t++) begin
            @(negedge clk);
            if (i < 0 && tip) i = 0;
            if (i >= 0) begin
                if (i == 0) req = 1'b0;
                if (i < len) begin
                    chk(tip == 1'b1, "R6 tip held through cycle", tip, 1);
                    chk(bclk == (i % 2 == 0), "R12 bus clock phase", bclk, (i % 2 == 0));
                    chk(ts == (i < 2), "R4 ts window", ts, (i < 2));
                    chk(cs == (i >= 1), "R3 cs window", cs, (i >= 1));
                    chk(oe == (!w && i >= 1), "R3 oe window", oe, (!w && i >= 1));
                    chk(be == ((i >= 1) ? eb : 4'b0), "R9 byte lanes", be, (i >= 1) ? eb : 4'b0);
                    chk(doe == (w && i >= 2), "R5 write drive window", doe, (w && i >= 2));
                    chk(addr_b == a && rw == !w && size_b == s, "R2 R10 cycle fields",
                        {addr_b, rw, size_b}, {a, !w, s});
                    chk(done == 1'b0, "R8 no early done", done, 0);
                    if (w && i >= 2) chk(wdata_b == wdv, "R5 write data", wdata_b, wdv);
                    if (poke && i == 3) begin req = 1'b1; addr = ~a; end
                    if (poke && i == len - 1) req = 1'b0;
                end else begin
                    chk(tip == 1'b0 && cs == 1'b0, "R6 R7 cycle length", {tip, cs}, 0);
                    chk(done == 1'b1, "R8 done pulse", done, 1);
                    if (!w) chk(rdata == sd, "R8 read data", rdata, sd);
                    ended = 1;
                end
                ack    = (i == 2 * d + 1);
                bus_rd = (i == 2 * d + 1) ? sd : 32'hDEAD_BEEF;
                i++;
            end
        end
        if (!ended) chk(0, "R6 cycle never ended", 0, 1);
        ack = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(tip == 1'b0 && done == 1'b0, "R10 idle after cycle", {tip, done}, 0);
            chk(rw == !w, "R11 direction held", rw, !w);
            if (!w) chk(rdata == sd, "R8 read data held", rdata, sd);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                chk(0, "watchdog expired", cyc, 0);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({tip, ts, cs, be, oe, doe, done, busy} == 0, "R1 outputs in reset",
            {tip, ts, cs, be, oe, doe, done, busy}, 0);
        chk(rw == 1'b1, "R1 rw in reset", rw, 1);
        rst = 1'b0;
        @(negedge clk);
        chk({tip, cs, done} == 0 && rw == 1'b1, "R1 after reset", {tip, cs, done, rw}, 1);

        do_xfer(1'b0, 24'h000100, 2'd2, 32'h0,         1, 32'h1234_5678, 0); // R6 normal read
        do_xfer(1'b1, 24'h000204, 2'd2, 32'hCAFE_F00D, 1, 32'h0,         0); // R5 write
        do_xfer(1'b0, 24'h000303, 2'd0, 32'h0,         0, 32'hA5A5_0001, 0); // R7 fast read
        do_xfer(1'b1, 24'h000402, 2'd1, 32'h1111_2222, 0, 32'h0,         0); // R7 fast write
        do_xfer(1'b0, 24'h000500, 2'd1, 32'h0,         4, 32'h0BAD_C0DE, 0); // R6 three waits
        do_xfer(1'b0, 24'h000601, 2'd0, 32'h0,         2, 32'h7777_8888, 1); // R10 poke
        do_xfer(1'b1, 24'h000702, 2'd0, 32'h5A5A_5A5A, 3, 32'h0,         0); // R9 byte lane 2
        do_xfer(1'b1, 24'h000800, 2'd3, 32'h0F0F_0F0F, 2, 32'h0,         0); // R9 code 3

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule